// File: doc/BRIEF.md
# Programming Status Flag Generator

This block drives two status pins of a nonvolatile-memory programming interface that a JTAG command channel controls. The ready pin shows whether a flash program or erase, or an EEPROM write, is in progress. The error pin is active low and sticky. It records a failed flash sector erase or a failed flash byte program, and it holds that record until the failure has been acknowledged.

The instruction decoder upstream sends single-cycle command strobes: enable, disable and clear. It also passes on the chip reset pulse. The memory engines supply busy levels and a per-bank flash error pulse. At enable time the open-drain select input chooses how the pins are driven. In push-pull mode each pin is driven both high and low. In open-drain mode the driver is only switched on to pull the pin low, so several devices can share one wired-OR line with an external pull-up. All outputs come from flops clocked on the system clock.

Top module: `prog_status_flags`

## Requirements
- R1: After reset, and whenever the interface is disabled, both output enables (`rdy_oe`, `err_oe`) and both pin values (`rdy_o`, `err_o`) are 0.
- R2: A 1 on any bit of `flash_err` latches the error. From the next clock edge on, the error pin level is low.
- R3: A latched error stays latched until one of two events clears it. The first is a `cmd_clear` strobe. The second is a `chip_rst` pulse that arrives while the interface is already disabled. Disabling the interface alone does not clear it.
- R4: EEPROM activity (`eep_busy`) never changes the error pin.
- R5: One edge after the inputs, the ready pin level is 1 when no bit of `flash_busy` is 1 and `eep_busy` is 0, and 0 otherwise.
- R6: `od_sel` is sampled only in the cycle of a `cmd_enable` strobe that takes effect. Its value in any other cycle has no effect.
- R7: A `chip_rst` pulse while the interface is enabled leaves a latched error in place.
- R8: If `cmd_clear` and a flash error pulse come in the same cycle, the error stays latched.
- R9: Pin encoding while enabled. In push-pull mode (`od_sel`=0 at enable), `*_oe`=1 and `*_o` equals the level. In open-drain mode (`od_sel`=1), `*_o`=0 and `*_oe` is 1 exactly when the level is 0.
- R10: If `cmd_enable` and `cmd_disable` come in the same cycle, the interface ends up disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cmd_enable | input | 1 | Enable command strobe |
| cmd_disable | input | 1 | Disable command strobe |
| cmd_clear | input | 1 | Error clear command strobe |
| od_sel | input | 1 | Open-drain select, sampled at enable |
| chip_rst | input | 1 | Chip reset pulse |
| flash_busy | input | FLASH_BANKS | Flash program/erase in progress, per bank |
| flash_err | input | FLASH_BANKS | Flash operation failure pulse, per bank |
| eep_busy | input | 1 | EEPROM write in progress |
| rdy_o | output | 1 | Ready/busy pin value |
| rdy_oe | output | 1 | Ready/busy pin driver enable |
| err_o | output | 1 | Error pin value (active low) |
| err_oe | output | 1 | Error pin driver enable |

## Verification
The hardest case is the reset-clears-error path. It needs a latched error, then a disable in one cycle, then a chip reset in a later cycle. While the interface is disabled the pins are off, so the clearing cannot be seen at that point. The stimulus therefore enables the interface again afterwards and reads the error pin. A control sequence does the same thing but leaves out the reset, which shows that the disable alone keeps the error. Same-cycle collisions (clear with error, enable with disable) are driven on one clock edge.

// File: rtl/psf_pkg.sv
package psf_pkg;
    typedef struct packed {
        logic en;    // interface enabled
        logic od;    // open-drain mode captured at enable
        logic err;   // sticky flash error
        logic busy;  // any engine busy
    } psf_state_t;
endpackage

// File: rtl/psf_ctrl.sv
module psf_ctrl
    import psf_pkg::*;
#(
    parameter int FLASH_BANKS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_enable,
    input  logic                   cmd_disable,
    input  logic                   cmd_clear,
    input  logic                   od_sel,
    input  logic                   chip_rst,
    input  logic [FLASH_BANKS-1:0] flash_busy,
    input  logic [FLASH_BANKS-1:0] flash_err,
    input  logic                   eep_busy,
    output psf_state_t             state_q
);
    psf_state_t state_d;

    always_comb begin
        state_d = state_q;
        // disable has priority over enable
        if (cmd_disable) begin
            state_d.en = 1'b0;
        end else if (cmd_enable) begin
            state_d.en = 1'b1;
            state_d.od = od_sel;
        end
        state_d.busy = (|flash_busy) | eep_busy;
        if (cmd_clear || (chip_rst && !state_q.en)) begin
            state_d.err = 1'b0;
        end
        // a new failure wins over any clear in the same cycle
        if (|flash_err) begin
            state_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/psf_pin_drv.sv
module psf_pin_drv (
    input  logic en,
    input  logic od,
    input  logic level,
    output logic pin_o,
    output logic pin_oe
);
    always_comb begin
        if (!en) begin
            pin_o  = 1'b0;
            pin_oe = 1'b0;
        end else if (od) begin
            pin_o  = 1'b0;
            pin_oe = ~level;
        end else begin
            pin_o  = level;
            pin_oe = 1'b1;
        end
    end
endmodule

// File: rtl/prog_status_flags.sv
module prog_status_flags
    import psf_pkg::*;
#(
    parameter int FLASH_BANKS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_enable,
    input  logic                   cmd_disable,
    input  logic                   cmd_clear,
    input  logic                   od_sel,
    input  logic                   chip_rst,
    input  logic [FLASH_BANKS-1:0] flash_busy,
    input  logic [FLASH_BANKS-1:0] flash_err,
    input  logic                   eep_busy,
    output logic                   rdy_o,
    output logic                   rdy_oe,
    output logic                   err_o,
    output logic                   err_oe
);
    localparam int NUM_PINS = 2;
    localparam int PIN_RDY  = 0;
    localparam int PIN_ERR  = 1;

    psf_state_t          state_q;
    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] pin_o;
    logic [NUM_PINS-1:0] pin_oe;

    psf_ctrl #(.FLASH_BANKS(FLASH_BANKS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_enable  (cmd_enable),
        .cmd_disable (cmd_disable),
        .cmd_clear   (cmd_clear),
        .od_sel      (od_sel),
        .chip_rst    (chip_rst),
        .flash_busy  (flash_busy),
        .flash_err   (flash_err),
        .eep_busy    (eep_busy),
        .state_q     (state_q)
    );

    assign level[PIN_RDY] = ~state_q.busy;
    assign level[PIN_ERR] = ~state_q.err;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        psf_pin_drv u_drv (
            .en     (state_q.en),
            .od     (state_q.od),
            .level  (level[i]),
            .pin_o  (pin_o[i]),
            .pin_oe (pin_oe[i])
        );
    end

    assign rdy_o  = pin_o[PIN_RDY];
    assign rdy_oe = pin_oe[PIN_RDY];
    assign err_o  = pin_o[PIN_ERR];
    assign err_oe = pin_oe[PIN_ERR];
endmodule

// File: rtl/psf_checker.sv
module psf_checker
    import psf_pkg::*;
#(
    parameter int FLASH_BANKS = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_enable,
    input logic                   cmd_disable,
    input logic                   cmd_clear,
    input logic                   chip_rst,
    input logic [FLASH_BANKS-1:0] flash_err,
    input logic [FLASH_BANKS-1:0] flash_busy,
    input logic                   eep_busy,
    input psf_state_t             st,
    input logic                   rdy_o,
    input logic                   rdy_oe,
    input logic                   err_o,
    input logic                   err_oe
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st.en |-> (!rdy_oe && !err_oe && !rdy_o && !err_o));

    // R2
    err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flash_err) |=> st.err);

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st.err && !cmd_clear && !(chip_rst && !st.en)) |=> st.err);

    // R4
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.err && !(|flash_err)) |=> !st.err);

    // R5
    busy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flash_busy) || eep_busy) |=> st.busy);

    // R9
    od_encode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st.en && st.od) |-> (!rdy_o && !err_o && (err_oe == st.err)));

    // R9
    pp_encode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st.en && !st.od) |-> (rdy_oe && err_oe && (err_o == !st.err)));

    // R10
    dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_enable && cmd_disable) |=> !st.en);
endmodule

bind prog_status_flags psf_checker #(.FLASH_BANKS(FLASH_BANKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_enable  (cmd_enable),
    .cmd_disable (cmd_disable),
    .cmd_clear   (cmd_clear),
    .chip_rst    (chip_rst),
    .flash_err   (flash_err),
    .flash_busy  (flash_busy),
    .eep_busy    (eep_busy),
    .st          (state_q),
    .rdy_o       (rdy_o),
    .rdy_oe      (rdy_oe),
    .err_o       (err_o),
    .err_oe      (err_oe)
);

// File: tb/prog_status_flags_test.sv
`timescale 1ns/1ps
module prog_status_flags_test;
    localparam int BANKS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_enable = 0, cmd_disable = 0, cmd_clear = 0, od_sel = 0, chip_rst = 0;
    logic [BANKS-1:0] flash_busy = '0, flash_err = '0;
    logic eep_busy = 0;
    logic rdy_o, rdy_oe, err_o, err_oe;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prog_status_flags #(.FLASH_BANKS(BANKS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .cmd_clear(cmd_clear), .od_sel(od_sel), .chip_rst(chip_rst),
        .flash_busy(flash_busy), .flash_err(flash_err), .eep_busy(eep_busy),
        .rdy_o(rdy_o), .rdy_oe(rdy_oe), .err_o(err_o), .err_oe(err_oe)
    );

    // compares {rdy_oe, rdy_o, err_oe, err_o}
    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {rdy_oe, rdy_o, err_oe, err_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // advance one clock; inputs driven before are seen on outputs after
    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        cmd_enable = 0; cmd_disable = 0; cmd_clear = 0; chip_rst = 0; flash_err = '0;
    endtask

    task automatic do_enable(input logic od);
        cmd_enable = 1; od_sel = od; step(); clear_strobes(); od_sel = 0;
    endtask

    task automatic do_disable();
        cmd_disable = 1; step(); clear_strobes();
    endtask

    task automatic t_reset();
        chk("R1 reset idle", 4'b0000);
    endtask

    task automatic t_busy_pp();
        do_enable(1'b0);
        chk("R9 push-pull idle", 4'b1111);
        flash_busy = 2'b10; step();
        chk("R5 flash bank busy", 4'b1011);
        flash_busy = '0; eep_busy = 1; step();
        chk("R5 eeprom busy", 4'b1011);
        chk("R4 eeprom write leaves error pin", 4'b1011);
        eep_busy = 0; step();
        chk("R5 ready again", 4'b1111);
    endtask

    task automatic t_err_sticky();
        flash_err = 2'b01; step(); clear_strobes();
        chk("R2 flash error latched", 4'b1110);
        step(); step();
        chk("R3 error held", 4'b1110);
        chip_rst = 1; step(); clear_strobes();
        chk("R7 reset while enabled keeps error", 4'b1110);
        cmd_clear = 1; flash_err = 2'b10; step(); clear_strobes();
        chk("R8 clear with new error", 4'b1110);
        cmd_clear = 1; step(); clear_strobes();
        chk("R3 clear command", 4'b1111);
    endtask

    task automatic t_reset_after_disable();
        flash_err = 2'b01; step(); clear_strobes();
        do_disable();
        chk("R1 disabled pins off", 4'b0000);
        do_enable(1'b0);
        chk("R3 disable alone keeps error", 4'b1110);
        do_disable();
        chip_rst = 1; step(); clear_strobes();
        do_enable(1'b0);
        chk("R3 reset after disable clears", 4'b1111);
    endtask

    task automatic t_open_drain();
        do_disable();
        do_enable(1'b1);
        chk("R9 open-drain idle released", 4'b0000);
        od_sel = 0; step();
        chk("R6 od_sel ignored after enable", 4'b0000);
        flash_busy = 2'b01; flash_err = 2'b01; step(); clear_strobes();
        chk("R9 open-drain both low driven", 4'b1010);
        flash_busy = '0; cmd_clear = 1; step(); clear_strobes();
        chk("R9 open-drain released again", 4'b0000);
    endtask

    task automatic t_collision();
        cmd_enable = 1; cmd_disable = 1; od_sel = 0; step(); clear_strobes();
        chk("R10 disable wins over enable", 4'b0000);
        do_enable(1'b0);
        chk("R6 push-pull after re-enable", 4'b1111);
    endtask

    initial begin
        repeat (2) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_busy_pp();
        t_err_sticky();
        t_reset_after_disable();
        t_open_drain();
        t_collision();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule